// File: doc/BRIEF.md
# Endpoint Handshake Status Register

This block is the control and status word of one device endpoint, together with the logic that picks the handshake for each token. The word holds two independent two-bit status fields, one for the transmit (IN) direction and one for the receive (OUT and SETUP) direction. It also holds a two-bit endpoint type and a single endpoint-kind bit. On a control endpoint, that bit means "a status stage is expected".

Software updates the word through a write port. The status fields never take the written value directly. A written one flips the matching status bit, and a written zero leaves it as it is. The type field and the kind bit load as written. When a token is presented, the block answers in the same cycle from the token type, the byte count and the current word. It answers with no reply, ACK (send data, for IN), NAK or STALL. When the completion strobe marks a correct transfer, the block moves the status of that direction to NAK, so that software can service the buffer. It also raises a one-cycle completion pulse.

Top module: `ep_hs_reg`

## Requirements
- R1: The word reads transmit status at bits 5:4, the kind bit at bit 8, the type at bits 10:9 and receive status at bits 13:12. All other bits read zero, and reset clears the whole word.
- R2: Encodings are as follows. Status: 00 disabled, 01 stall, 10 nak, 11 valid. Type: 00 bulk, 01 control, 10 isochronous, 11 interrupt. Token: 00 OUT, 01 IN, 10 SETUP, 11 reserved, which gets no reply. Handshake: 00 none, 01 ACK/data, 10 NAK, 11 STALL.
- R3: On a write, each written 1 in a status field inverts that status bit and each 0 keeps it. The type and kind bits take the written value. The new word is visible the cycle after the write.
- R4: OUT is answered from the receive status and IN from the transmit status. Disabled gives no reply, stall gives STALL, nak gives NAK and valid gives ACK.
- R5: A SETUP on a non-control endpoint gets no reply. With a completion strobe it changes no status and raises no completion pulse.
- R6: A SETUP on a control endpoint gets no reply when receive status is nak or disabled. It gets ACK when receive status is stall or valid.
- R7: On a control endpoint with the kind bit set, an OUT with a non-zero byte count and valid receive status gets STALL. A zero-length OUT still gets ACK. On other types the kind bit has no effect on the reply.
- R8: A completion strobe with an ACK reply on a non-isochronous endpoint sets the status to nak on the next cycle. A SETUP or OUT sets the receive status, and an IN sets the transmit status.
- R9: On an isochronous endpoint, a completed transfer leaves both status fields unchanged.
- R10: done_irq pulses for exactly one cycle, the cycle after each completion strobe whose reply was ACK.
- R11: When a write and a hardware nak update hit the same cycle, the write toggles apply to the nak value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register word |
| tok_vld | input | 1 | A token is being presented |
| tok_kind | input | 2 | Token type (R2) |
| tok_len | input | CNT_W (10) | Payload byte count of the token |
| xfer_done | input | 1 | Transfer completed correctly (qualified by tok_vld) |
| hs_code | output | 2 | Handshake to send, combinational (R2) |
| done_irq | output | 1 | Completion pulse |

## Verification
On every cycle, the assertions check the following. Non-control SETUPs get no reply. The status-stage STALL rule holds. Correct transfers leave the right direction at nak. Isochronous status stays fixed without a write. done_irq only follows a completion. Some behaviours show only in the bench scenarios, which compare against a reference model. These are the toggle arithmetic, the same-cycle merge of a write and a hardware update, and the SETUP acceptance rules over every status value.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    localparam int TX_LSB   = 4;
    localparam int KIND_BIT = 8;
    localparam int TYPE_LSB = 9;
    localparam int RX_LSB   = 12;
    localparam int STAT_W   = 2;

    typedef enum logic [1:0] {
        ST_DIS   = 2'b00,
        ST_STALL = 2'b01,
        ST_NAK   = 2'b10,
        ST_VALID = 2'b11
    } stat_e;

    typedef enum logic [1:0] {
        EP_BULK = 2'b00,
        EP_CTRL = 2'b01,
        EP_ISO  = 2'b10,
        EP_INTR = 2'b11
    } ep_type_e;

    typedef enum logic [1:0] {
        TK_OUT   = 2'b00,
        TK_IN    = 2'b01,
        TK_SETUP = 2'b10,
        TK_RSVD  = 2'b11
    } tok_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef struct packed {
        ep_type_e typ;
        logic     kind;
    } ep_cfg_t;

    // Plain mapping of a status field to the reply it gives
    function automatic hs_e stat_answer(stat_e s);
        case (s)
            ST_STALL: return HS_STALL;
            ST_NAK:   return HS_NAK;
            ST_VALID: return HS_ACK;
            default:  return HS_NONE;
        endcase
    endfunction

    function automatic int stat_lsb(int dir);
        return (dir == 0) ? TX_LSB : RX_LSB;
    endfunction

endpackage

// File: rtl/ep_hs_stat_fld.sv
module ep_hs_stat_fld
    import ep_hs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_nak,
    input  logic [STAT_W-1:0]   tgl,
    output stat_e               stat
);
    stat_e after_hw;

    always_comb begin
        after_hw = hw_nak ? ST_NAK : stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= ST_DIS;
        end else begin
            stat <= stat_e'(after_hw ^ tgl);
        end
    end
endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import ep_hs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  ep_cfg_t           cfg,
    input  stat_e             tx_stat,
    input  stat_e             rx_stat,
    input  logic              tok_vld,
    input  tok_e              tok,
    input  logic [CNT_W-1:0]  len,
    output hs_e               hs
);
    logic is_ctrl;
    logic status_stage;

    always_comb begin
        is_ctrl      = (cfg.typ == EP_CTRL);
        status_stage = is_ctrl && cfg.kind && (len != '0);
        hs           = HS_NONE;
        if (tok_vld) begin
            case (tok)
                TK_IN: hs = stat_answer(tx_stat);
                TK_OUT: begin
                    hs = stat_answer(rx_stat);
                    if (hs == HS_ACK && status_stage) begin
                        hs = HS_STALL;
                    end
                end
                TK_SETUP: begin
                    if (is_ctrl && (rx_stat == ST_STALL || rx_stat == ST_VALID)) begin
                        hs = HS_ACK;
                    end
                end
                default: hs = HS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ep_hs_reg.sv
module ep_hs_reg
    import ep_hs_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              tok_vld,
    input  logic [1:0]        tok_kind,
    input  logic [CNT_W-1:0]  tok_len,
    input  logic              xfer_done,
    output logic [1:0]        hs_code,
    output logic              done_irq
);
    localparam int NDIR = 2;

    ep_cfg_t cfg;
    stat_e   stat_q [NDIR];
    logic    hw_nak [NDIR];
    tok_e    tok;
    hs_e     hs;
    logic    good_xfer;
    logic    hw_upd;

    assign tok = tok_e'(tok_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{typ: EP_BULK, kind: 1'b0};
            done_irq <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg.typ  <= ep_type_e'(wr_data[TYPE_LSB +: 2]);
                cfg.kind <= wr_data[KIND_BIT];
            end
            done_irq <= good_xfer;
        end
    end

    ep_hs_decide #(.CNT_W(CNT_W)) u_decide (
        .cfg     (cfg),
        .tx_stat (stat_q[0]),
        .rx_stat (stat_q[1]),
        .tok_vld (tok_vld),
        .tok     (tok),
        .len     (tok_len),
        .hs      (hs)
    );

    assign good_xfer = tok_vld && xfer_done && (hs == HS_ACK);
    assign hw_upd    = good_xfer && (cfg.typ != EP_ISO);
    assign hw_nak[0] = hw_upd && (tok == TK_IN);
    assign hw_nak[1] = hw_upd && (tok == TK_OUT || tok == TK_SETUP);

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        localparam int LSB = stat_lsb(g);
        logic [STAT_W-1:0] tgl;
        assign tgl = wr_en ? wr_data[LSB +: STAT_W] : '0;
        ep_hs_stat_fld u_fld (
            .clk    (clk),
            .rst    (rst),
            .hw_nak (hw_nak[g]),
            .tgl    (tgl),
            .stat   (stat_q[g])
        );
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[TX_LSB +: STAT_W]    = stat_q[0];
        rd_data[RX_LSB +: STAT_W]    = stat_q[1];
        rd_data[KIND_BIT]            = cfg.kind;
        rd_data[TYPE_LSB +: 2]       = cfg.typ;
    end

    assign hs_code = hs;
endmodule

// File: rtl/ep_hs_chk.sv
module ep_hs_chk #(
    parameter int REG_W = 16,
    parameter int CNT_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  rd_data,
    input logic              tok_vld,
    input logic [1:0]        tok_kind,
    input logic [CNT_W-1:0]  tok_len,
    input logic              xfer_done,
    input logic [1:0]        hs_code,
    input logic              done_irq
);
    logic [1:0] typ, txs, rxs;
    logic       kind, ok;
    assign typ  = rd_data[10:9];
    assign txs  = rd_data[5:4];
    assign rxs  = rd_data[13:12];
    assign kind = rd_data[8];
    assign ok   = tok_vld && xfer_done && (hs_code == 2'b01);

    AST_SETUP_NONCTRL: assert property (@(posedge clk) disable iff (rst)
        (tok_vld && tok_kind == 2'b10 && typ != 2'b01) |-> hs_code == 2'b00); // R5

    AST_STATUS_STAGE: assert property (@(posedge clk) disable iff (rst)
        (tok_vld && tok_kind == 2'b00 && typ == 2'b01 && kind && rxs == 2'b11 && tok_len != '0)
        |-> hs_code == 2'b11); // R7

    AST_RX_NAK_AFTER: assert property (@(posedge clk) disable iff (rst)
        (ok && tok_kind != 2'b01 && typ != 2'b10 && !wr_en) |=> rxs == 2'b10); // R8

    AST_TX_NAK_AFTER: assert property (@(posedge clk) disable iff (rst)
        (ok && tok_kind == 2'b01 && typ != 2'b10 && !wr_en) |=> txs == 2'b10); // R8

    AST_ISO_FIXED: assert property (@(posedge clk) disable iff (rst)
        (typ == 2'b10 && !wr_en) |=> $stable(rd_data)); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> $past(xfer_done && tok_vld)); // R10

    AST_IRQ_ONE: assert property (@(posedge clk) disable iff (rst)
        ok |=> done_irq); // R10
endmodule

bind ep_hs_reg ep_hs_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .tok_vld   (tok_vld),
    .tok_kind  (tok_kind),
    .tok_len   (tok_len),
    .xfer_done (xfer_done),
    .hs_code   (hs_code),
    .done_irq  (done_irq)
);

// File: tb/ep_hs_reg_bench.sv
`timescale 1ns/1ps
module ep_hs_reg_bench;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [15:0]      wr_data = '0;
    logic [15:0]      rd_data;
    logic             tok_vld = 1'b0;
    logic [1:0]       tok_kind = '0;
    logic [CNT_W-1:0] tok_len = '0;
    logic             xfer_done = 1'b0;
    logic [1:0]       hs_code;
    logic             done_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [1:0] m_tx = 0, m_rx = 0, m_typ = 0;
    logic       m_kind = 0;

    always #2.5 clk = ~clk;

    ep_hs_reg #(.REG_W(16), .CNT_W(CNT_W)) u_ep_hs_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tok_vld(tok_vld), .tok_kind(tok_kind), .tok_len(tok_len),
        .xfer_done(xfer_done), .hs_code(hs_code), .done_irq(done_irq)
    );

    function automatic logic [1:0] ans(logic [1:0] s);
        case (s)
            2'b01: return 2'b11;
            2'b10: return 2'b10;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] exp_hs(logic [1:0] tk, logic [CNT_W-1:0] len);
        case (tk)
            2'b01: return ans(m_tx);
            2'b00: begin
                if (m_rx == 2'b11 && m_typ == 2'b01 && m_kind && len != 0) return 2'b11;
                return ans(m_rx);
            end
            2'b10: return (m_typ == 2'b01 && (m_rx == 2'b01 || m_rx == 2'b11)) ? 2'b01 : 2'b00;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [15:0] exp_word();
        logic [15:0] w = '0;
        w[5:4] = m_tx; w[8] = m_kind; w[10:9] = m_typ; w[13:12] = m_rx;
        return w;
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check reply, clock, check word and pulse
    task automatic op(string tag, logic w, logic [15:0] wd, logic tv,
                      logic [1:0] tk, logic [CNT_W-1:0] len, logic dn);
        logic [1:0] h;
        logic       irq;
        @(negedge clk);
        wr_en = w; wr_data = wd; tok_vld = tv; tok_kind = tk; tok_len = len; xfer_done = dn;
        #1;
        h = tv ? exp_hs(tk, len) : 2'b00;
        if (tv) check(tag, "handshake", {14'b0, hs_code}, {14'b0, h});
        irq = tv && dn && h == 2'b01;
        if (irq && m_typ != 2'b10) begin
            if (tk == 2'b01) m_tx = 2'b10; else m_rx = 2'b10;
        end
        if (w) begin
            m_tx = m_tx ^ wd[5:4]; m_rx = m_rx ^ wd[13:12];
            m_typ = wd[10:9]; m_kind = wd[8];
        end
        @(posedge clk);
        #1;
        wr_en = 0; tok_vld = 0; xfer_done = 0;
        check(tag, "word", rd_data, exp_word());
        check(tag, "done_irq", {15'b0, done_irq}, {15'b0, irq});
    endtask

    task automatic set_state(string tag, logic [1:0] typ, logic kind, logic [1:0] tx, logic [1:0] rx);
        logic [15:0] wd = '0;
        wd[5:4] = m_tx ^ tx; wd[13:12] = m_rx ^ rx; wd[10:9] = typ; wd[8] = kind;
        op(tag, 1, wd, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 check("R1", "reset word", rd_data, 16'h0000);
        check("R10", "reset irq", {15'b0, done_irq}, 16'h0);

        // R1 R3: unrelated bits read zero, toggles
        op("R1", 1, 16'hFFFF, 0, 0, 0, 0);
        op("R3", 1, 16'h1010, 0, 0, 0, 0);
        op("R3", 1, 16'h0000, 0, 0, 0, 0);
        // R4: all status values for IN and OUT on bulk
        for (int s = 0; s < 4; s++) begin
            set_state("R3", 2'b00, 0, s[1:0], s[1:0]);
            op("R4", 0, 0, 1, 2'b01, 8, 0);
            op("R4", 0, 0, 1, 2'b00, 8, 0);
            op("R2", 0, 0, 1, 2'b11, 8, 1);
        end
        // R5: setup on bulk with valid rx, completion ignored
        set_state("R5", 2'b00, 0, 2'b11, 2'b11);
        op("R5", 0, 0, 1, 2'b10, 8, 1);
        // R6: setup on control over all rx values
        for (int s = 0; s < 4; s++) begin
            set_state("R6", 2'b01, 0, 2'b11, s[1:0]);
            op("R6", 0, 0, 1, 2'b10, 8, 1);
        end
        // R7: status stage
        set_state("R7", 2'b01, 1, 2'b11, 2'b11);
        op("R7", 0, 0, 1, 2'b00, 5, 1);
        op("R7", 0, 0, 1, 2'b00, 0, 1);
        set_state("R7", 2'b11, 1, 2'b11, 2'b11);
        op("R7", 0, 0, 1, 2'b00, 5, 0);
        // R8 R10: completions
        set_state("R8", 2'b00, 0, 2'b11, 2'b11);
        op("R8", 0, 0, 1, 2'b01, 4, 1);
        op("R8", 0, 0, 1, 2'b00, 4, 1);
        // R9: iso holds
        set_state("R9", 2'b10, 0, 2'b11, 2'b11);
        op("R9", 0, 0, 1, 2'b01, 4, 1);
        op("R9", 0, 0, 1, 2'b00, 4, 1);
        // R11: write and hw update same cycle: valid->nak then toggle 01 -> 11
        set_state("R11", 2'b00, 0, 2'b11, 2'b11);
        op("R11", 1, 16'h1010, 1, 2'b00, 4, 1);
        op("R11", 1, 16'h0010, 1, 2'b01, 4, 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] wd;
            wd = 16'($urandom);
            op("R8", ($urandom % 4) == 0, wd, ($urandom % 4) != 0,
               2'($urandom), CNT_W'($urandom % 3), ($urandom % 2) == 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule